// File: doc/BRIEF.md
# Dual Up/Down Timer with Shared Capture/Reload Register

The block holds two 16-bit up/down timers, a core timer and an auxiliary timer, plus one 16-bit capture/reload register that both of them use. Each timer steps on ticks from its own clock divider, or on rising edges of its own external count pin. The auxiliary timer has a third option: it can step on every change of the core timer's toggle latch, which chains the two timers into one longer counter.

Every time the core timer overflows or underflows, the toggle latch inverts and a one-cycle wrap pulse goes out. If reload is enabled, the core timer then restarts from the capture/reload register. The auxiliary timer's value is copied into that same register on a selected edge of the capture pin, or on any change of either alternate trigger pin. After the copy the auxiliary timer can be cleared, so that it measures the interval between capture events.

Software programs the block through a single-cycle register write port. A combinational read port returns the register values.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all five registers read 0, and `tgl_out` and `wrap_pulse` are 0.
- R2: Register map. Address 0 is the core control register, 1 the auxiliary control register, 2 the core count, 3 the auxiliary count and 4 the capture/reload register. Control bits [2:0] select the divider; the divide ratio is 4 shifted left by that code (4 to 512). A write to a timer's count or control register restarts that timer's divider. The timer then steps on every edge that is a multiple of the ratio after the write edge.
- R3: Control bit 4 set means count down. When control bit 5 is set, the synchronized level of that timer's direction pin is XORed into bit 4. Counting down from 0 gives 0xFFFF.
- R4: With control bit 3 (run) clear, the timer holds its value.
- R5: Control bits [7:6] choose what the timer steps on: 00 selects divider ticks and 01 selects rising edges of the timer's external count pin.
- R6: `tgl_out` inverts on every core overflow (0xFFFF while counting up) and every core underflow (0 while counting down). At no other time does it change.
- R7: `wrap_pulse` is high for exactly the one cycle after each core wrap. The toggle latch changes on that same edge.
- R8: When core control bit 8 is set, a core wrap loads the capture/reload register instead of the wrapped value.
- R9: Auxiliary source code 10 steps the auxiliary timer once per core wrap, on the edge after the toggle latch changes.
- R10: Auxiliary bits [9:8] select which capture-pin edge copies the auxiliary count into the capture/reload register: 00 none, 01 rising, 10 falling, 11 both. Capture-pin edges that are not selected are ignored.
- R11: When auxiliary bit 10 is set, a capture clears the auxiliary timer.
- R12: Auxiliary bits 11 and 12 each let any change on alternate pin A or pin B, respectively, trigger a capture. A disabled alternate pin is ignored.
- R13: A register write takes precedence over a count, reload or capture to the same register in the same cycle.
- R14: Each pin passes through two synchronizing flops. A pin change takes effect on the third rising clock edge after it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| core_ext_in | input | 1 | Core external count pin |
| core_dir_in | input | 1 | Core direction pin |
| aux_ext_in | input | 1 | Auxiliary external count pin |
| aux_dir_in | input | 1 | Auxiliary direction pin |
| cap_in | input | 1 | Capture pin |
| alt_a_in | input | 1 | Alternate capture trigger A |
| alt_b_in | input | 1 | Alternate capture trigger B |
| tgl_out | output | 1 | Core toggle latch |
| wrap_pulse | output | 1 | One-cycle pulse after a core wrap |

## Verification
The counting core is run through a table that covers all eight divider codes, in both directions and from several start values. Each row has a window length chosen so that an off-by-one in the divide ratio, or a ratio that uses the wrong shift, gives a different final count. It also includes a row that underflows through zero.

Capture is tried with rising, falling and both-edge selection, and with each alternate pin enabled and disabled. The unselected cases are checked alongside the selected ones, which separates a correct edge decoder from one that fires on every change.

Directed cases cover a reload on overflow, a natural underflow, two wraps chained into the auxiliary timer, pin latency, and a write in the same cycle as a step or a capture.

// File: rtl/tmr_pkg.sv
// Shared constants for the timer pair: register addresses and pin indices.
// Assumes the default 3-bit divider code; control fields are placed in the
// top module relative to that width.
package tmr_pkg;
    localparam int ADR_CORE_CTL = 0;
    localparam int ADR_AUX_CTL  = 1;
    localparam int ADR_CORE_CNT = 2;
    localparam int ADR_AUX_CNT  = 3;
    localparam int ADR_CAPREL   = 4;

    localparam int PIN_N        = 7;
    localparam int PIN_CORE_EXT = 0;   // +1 for aux
    localparam int PIN_CORE_DIR = 2;   // +1 for aux
    localparam int PIN_CAP      = 4;
    localparam int PIN_ALT_A    = 5;
    localparam int PIN_ALT_B    = 6;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_CHAIN = 2'b10,
        SRC_NONE = 2'b11
    } src_e;
endpackage

// File: rtl/tmr_pin_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins, plus a third flop
// used for edge detection. Assumes the pins are held low during reset.
module tmr_pin_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1, s2, s3;

    // Shift the pins through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
endmodule

// File: rtl/tmr_prediv.sv
// Restartable clock divider. Produces one tick every (4 << code) cycles,
// counted from the last restart. Assumes code changes only with a restart.
module tmr_prediv #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [PW-1:0] code,
    output logic          tick
);
    localparam int PCW = (1 << PW) + 2;

    logic [PCW-1:0] pc;
    logic [PCW-1:0] last;

    assign last = (PCW'(4) << code) - PCW'(1);
    assign tick = (pc == last);

    // Count cycles; wrap to zero on a tick or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)              pc <= '0;
        else if (restart || tick) pc <= '0;
        else                     pc <= pc + PCW'(1);
    end
endmodule

// File: rtl/tmr_updown.sv
// Up/down counter with load, clear and reload-on-wrap. Priority is
// load > clear > step. The wrap flag is combinational and is set only when
// a step actually wraps the counter.
module tmr_updown #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          down,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          clr,
    input  logic          rl_en,
    input  logic [CW-1:0] rl_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    logic at_lim;

    assign at_lim = down ? (cnt == '0) : (cnt == '1);
    assign wrap   = step && !ld && !clr && at_lim;

    // Update the count according to the load/clear/step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (ld)          cnt <= ld_val;
        else if (clr)         cnt <= '0;
        else if (step) begin
            if (wrap && rl_en) cnt <= rl_val;
            else if (down)     cnt <= cnt - CW'(1);
            else               cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/tmr_pair.sv
// Core and auxiliary up/down timers sharing one capture/reload register.
// The core timer's wraps toggle an output latch, pulse an output, can
// reload the core timer and can step the auxiliary timer. Pin edges capture
// the auxiliary timer. Assumes all pins are asynchronous and low in reset.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 3,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          core_ext_in,
    input  logic          core_dir_in,
    input  logic          aux_ext_in,
    input  logic          aux_dir_in,
    input  logic          cap_in,
    input  logic          alt_a_in,
    input  logic          alt_b_in,
    output logic          tgl_out,
    output logic          wrap_pulse
);
    localparam int RUN_B  = PW;
    localparam int DN_B   = PW + 1;
    localparam int XD_B   = PW + 2;
    localparam int SRC_L  = PW + 3;
    localparam int RL_B   = PW + 5;
    localparam int CE_L   = PW + 5;
    localparam int CLR_B  = PW + 7;
    localparam int ALTA_B = PW + 8;
    localparam int ALTB_B = PW + 9;

    logic [CW-1:0]    ctl_q [2];
    logic [CW-1:0]    cnt_q [2];
    logic             wrap_c [2];
    logic [CW-1:0]    caprel;
    logic             wrap_q, tgl_q;
    logic             cap_evt;
    logic [PIN_N-1:0] pins, lvl, rise, fall;
    logic [1:0]       ce;

    assign pins = {alt_b_in, alt_a_in, cap_in, aux_dir_in, core_dir_in,
                   aux_ext_in, core_ext_in};

    tmr_pin_sync #(.N(PIN_N)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .pin (pins),
        .lvl (lvl),
        .rise (rise),
        .fall (fall)
    );

    // Control register writes for both timers.
    always_ff @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (!rst_n)
                ctl_q[g] <= '0;
            else if (reg_we && reg_addr == AW'(ADR_CORE_CTL + g))
                ctl_q[g] <= reg_wdata;
        end
    end

    // Capture event from the selected capture edge or enabled alternate pins.
    assign ce = ctl_q[1][CE_L+1:CE_L];
    always_comb begin
        cap_evt = 1'b0;
        unique case (ce)
            2'b01:   cap_evt = rise[PIN_CAP];
            2'b10:   cap_evt = fall[PIN_CAP];
            2'b11:   cap_evt = rise[PIN_CAP] | fall[PIN_CAP];
            default: cap_evt = 1'b0;
        endcase
        if (ctl_q[1][ALTA_B] && (rise[PIN_ALT_A] || fall[PIN_ALT_A])) cap_evt = 1'b1;
        if (ctl_q[1][ALTB_B] && (rise[PIN_ALT_B] || fall[PIN_ALT_B])) cap_evt = 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_tmr
        logic pre_tick, step, down, restart, ld, clr, rl_en;
        src_e src;

        assign restart = reg_we && (reg_addr == AW'(ADR_CORE_CTL + g) ||
                                    reg_addr == AW'(ADR_CORE_CNT + g));
        assign ld      = reg_we && reg_addr == AW'(ADR_CORE_CNT + g);
        assign src     = src_e'(ctl_q[g][SRC_L+1:SRC_L]);
        assign down    = ctl_q[g][DN_B] ^ (ctl_q[g][XD_B] & lvl[PIN_CORE_DIR + g]);

        tmr_prediv #(.PW(PW)) u_div (
            .clk (clk),
            .rst_n (rst_n),
            .restart (restart),
            .code (ctl_q[g][PW-1:0]),
            .tick (pre_tick)
        );

        // Pick the step source for this timer, gated by its run bit.
        always_comb begin
            unique case (src)
                SRC_DIV:   step = pre_tick;
                SRC_EXT:   step = rise[PIN_CORE_EXT + g];
                SRC_CHAIN: step = (g == 1) ? wrap_q : 1'b0;
                default:   step = 1'b0;
            endcase
            step = step & ctl_q[g][RUN_B];
        end

        if (g == 0) begin : g_core
            assign clr   = 1'b0;
            assign rl_en = ctl_q[0][RL_B];
        end else begin : g_aux
            assign clr   = cap_evt & ctl_q[1][CLR_B];
            assign rl_en = 1'b0;
        end

        tmr_updown #(.CW(CW)) u_cnt (
            .clk (clk),
            .rst_n (rst_n),
            .step (step),
            .down (down),
            .ld (ld),
            .ld_val (reg_wdata),
            .clr (clr),
            .rl_en (rl_en),
            .rl_val (caprel),
            .cnt (cnt_q[g]),
            .wrap (wrap_c[g])
        );
    end

    // Capture/reload register: software write wins over a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      caprel <= '0;
        else if (reg_we && reg_addr == AW'(ADR_CAPREL)) caprel <= reg_wdata;
        else if (cap_evt)                               caprel <= cnt_q[1];
    end

    // Register the core wrap into the pulse and the toggle latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
            tgl_q  <= 1'b0;
        end else begin
            wrap_q <= wrap_c[0];
            if (wrap_c[0]) tgl_q <= ~tgl_q;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (int'(reg_addr))
            ADR_CORE_CTL: reg_rdata = ctl_q[0];
            ADR_AUX_CTL:  reg_rdata = ctl_q[1];
            ADR_CORE_CNT: reg_rdata = cnt_q[0];
            ADR_AUX_CNT:  reg_rdata = cnt_q[1];
            ADR_CAPREL:   reg_rdata = caprel;
            default:      reg_rdata = '0;
        endcase
    end

    assign tgl_out    = tgl_q;
    assign wrap_pulse = wrap_q;
endmodule

// File: rtl/tmr_pair_chk.sv
// Property checker for tmr_pair, attached with bind. Observes ports and a
// few internal nets; drives nothing.
module tmr_pair_chk #(
    parameter int CW = 16,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [CW-1:0] reg_wdata,
    input logic          tgl_out,
    input logic          wrap_pulse,
    input logic          core_run,
    input logic [CW-1:0] core_cnt,
    input logic [CW-1:0] aux_cnt,
    input logic [CW-1:0] caprel,
    input logic          cap_evt,
    input logic          aux_clr_en
);
    // R6
    tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (tgl_out != $past(tgl_out)));
    // R6
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_pulse |-> $stable(tgl_out));
    // R7
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);
    // R13
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(2)) |=> core_cnt == $past(reg_wdata));
    // R4
    core_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run && !(reg_we && reg_addr == AW'(2))) |=> $stable(core_cnt));
    // R10
    cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !(reg_we && reg_addr == AW'(4))) |=> caprel == $past(aux_cnt));
    // R11
    cap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && aux_clr_en && !(reg_we && reg_addr == AW'(3))) |=> aux_cnt == '0);
endmodule

bind tmr_pair tmr_pair_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .reg_we (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata (reg_wdata),
    .tgl_out (tgl_out),
    .wrap_pulse (wrap_pulse),
    .core_run (ctl_q[0][3]),
    .core_cnt (cnt_q[0]),
    .aux_cnt (cnt_q[1]),
    .caprel (caprel),
    .cap_evt (cap_evt),
    .aux_clr_en (ctl_q[1][10])
);

// File: tb/sim_tmr_pair.sv
// Self-checking bench for tmr_pair: a table of divider cases, then directed
// tests for wrap, reload, cascade, pins and capture.
module sim_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic core_ext_in = 0, core_dir_in = 0, aux_ext_in = 0, aux_dir_in = 0;
    logic cap_in = 0, alt_a_in = 0, alt_b_in = 0;
    logic tgl_out, wrap_pulse;
    int   checks = 0, errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    tmr_pair u0 (.*);

    // {code, down, start, cycles, expected}
    localparam logic [51:0] VEC [10] = '{
        {3'd0, 1'b0, 16'd0,   16'd40,   16'd10},
        {3'd1, 1'b0, 16'd0,   16'd40,   16'd5},
        {3'd2, 1'b0, 16'd0,   16'd64,   16'd4},
        {3'd3, 1'b0, 16'd0,   16'd100,  16'd3},
        {3'd4, 1'b0, 16'd0,   16'd130,  16'd2},
        {3'd5, 1'b0, 16'd0,   16'd128,  16'd1},
        {3'd6, 1'b0, 16'd0,   16'd255,  16'd0},
        {3'd7, 1'b0, 16'd0,   16'd1024, 16'd2},
        {3'd0, 1'b1, 16'd100, 16'd40,   16'd90},
        {3'd2, 1'b1, 16'd2,   16'd48,   16'hFFFF}
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        t0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk("R1 reg", v, 16'h0);
        end
        chk("R1 tgl", {15'd0, tgl_out}, 16'd0);
        chk("R1 wrap", {15'd0, wrap_pulse}, 16'd0);

        // R2/R3 divider table
        for (int i = 0; i < 10; i++) begin
            wr(3'd0, 16'(VEC[i][51:49]) | 16'h0008 | (16'(VEC[i][48]) << 4));
            wr(3'd2, VEC[i][47:32]);
            repeat (int'(VEC[i][31:16])) @(posedge clk);
            rd(3'd2, v);
            chk(VEC[i][48] ? "R3 down table" : "R2 divider table", v, VEC[i][15:0]);
        end

        // R8/R6/R7 overflow with reload
        t0 = tgl_out;
        wr(3'd4, 16'hFFF0);
        wr(3'd0, 16'h0108);
        wr(3'd2, 16'hFFFE);
        repeat (8) @(posedge clk);
        rd(3'd2, v); chk("R8 reload", v, 16'hFFF0);
        chk("R6 toggle", {15'd0, tgl_out}, {15'd0, ~t0});
        chk("R7 pulse high", {15'd0, wrap_pulse}, 16'd1);
        @(negedge clk);
        chk("R7 pulse low", {15'd0, wrap_pulse}, 16'd0);

        // R3/R8 underflow without reload
        wr(3'd0, 16'h0018);
        wr(3'd2, 16'h0001);
        repeat (8) @(posedge clk);
        rd(3'd2, v); chk("R3 underflow", v, 16'hFFFF);
        chk("R6 toggle back", {15'd0, tgl_out}, {15'd0, t0});

        // R4 run bit clear holds
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0007);
        repeat (40) @(posedge clk);
        rd(3'd2, v); chk("R4 hold", v, 16'h0007);

        // R3 direction pin
        core_dir_in = 1'b1;
        repeat (4) @(posedge clk);
        wr(3'd0, 16'h0028);
        wr(3'd2, 16'd100);
        repeat (40) @(posedge clk);
        rd(3'd2, v); chk("R3 dir pin", v, 16'd90);
        core_dir_in = 1'b0;

        // R14 pin latency, R5 external count
        wr(3'd0, 16'h0048);
        wr(3'd2, 16'h0000);
        @(negedge clk) core_ext_in = 1'b1;
        repeat (2) @(posedge clk);
        rd(3'd2, v); chk("R14 not yet", v, 16'd0);
        rd(3'd2, v); chk("R14 third edge", v, 16'd1);
        @(negedge clk) core_ext_in = 1'b0;
        for (int i = 0; i < 2; i++) begin
            repeat (2) @(negedge clk);
            core_ext_in = 1'b1;
            repeat (2) @(negedge clk);
            core_ext_in = 1'b0;
        end
        repeat (4) @(posedge clk);
        rd(3'd2, v); chk("R5 ext count", v, 16'd3);

        // R13 count write in same cycle as a step
        wr(3'd0, 16'h0008);
        repeat (3) @(posedge clk);
        wr(3'd2, 16'h0100);
        rd(3'd2, v); chk("R13 write beats step", v, 16'h0100);

        // R9 cascade: two core wraps step aux twice
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0088);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'hFFFE);
        wr(3'd0, 16'h0108);
        wr(3'd2, 16'hFFFE);
        t0 = tgl_out;
        repeat (20) @(posedge clk);
        rd(3'd3, v); chk("R9 cascade", v, 16'd2);
        chk("R6 two flips", {15'd0, tgl_out}, {15'd0, t0});
        wr(3'd0, 16'h0000);

        // R10/R11 rising capture with clear
        wr(3'd1, 16'h0500);
        wr(3'd3, 16'h1234);
        @(negedge clk) cap_in = 1'b1;
        settle();
        rd(3'd4, v); chk("R10 rise capture", v, 16'h1234);
        rd(3'd3, v); chk("R11 clear", v, 16'h0000);

        // R10 falling edge ignored when rising selected
        wr(3'd3, 16'h5555);
        @(negedge clk) cap_in = 1'b0;
        settle();
        rd(3'd4, v); chk("R10 fall ignored", v, 16'h1234);
        rd(3'd3, v); chk("R11 no clear", v, 16'h5555);

        // R10 both edges, no clear
        wr(3'd1, 16'h0300);
        @(negedge clk) cap_in = 1'b1;
        settle();
        rd(3'd4, v); chk("R10 both edges", v, 16'h5555);
        rd(3'd3, v); chk("R11 clear off", v, 16'h5555);

        // R10 falling selected
        wr(3'd1, 16'h0200);
        wr(3'd3, 16'h0777);
        @(negedge clk) cap_in = 1'b0;
        settle();
        rd(3'd4, v); chk("R10 fall capture", v, 16'h0777);

        // R12 alternate pins
        wr(3'd1, 16'h0000);
        wr(3'd3, 16'h0888);
        @(negedge clk) alt_a_in = 1'b1;
        settle();
        rd(3'd4, v); chk("R12 alt A disabled", v, 16'h0777);
        wr(3'd1, 16'h0800);
        @(negedge clk) alt_a_in = 1'b0;
        settle();
        rd(3'd4, v); chk("R12 alt A enabled", v, 16'h0888);
        wr(3'd1, 16'h1000);
        wr(3'd3, 16'h0999);
        @(negedge clk) alt_a_in = 1'b1;
        settle();
        rd(3'd4, v); chk("R12 alt A off, B on", v, 16'h0888);
        @(negedge clk) alt_b_in = 1'b1;
        settle();
        rd(3'd4, v); chk("R12 alt B", v, 16'h0999);

        // R13 capture/reload write beats a capture
        wr(3'd1, 16'h0100);
        wr(3'd3, 16'h0AAA);
        @(negedge clk) cap_in = 1'b1;
        repeat (2) @(posedge clk);
        wr(3'd4, 16'hBEEF);
        rd(3'd4, v); chk("R13 write beats capture", v, 16'hBEEF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule